// File: doc/BRIEF.md
# Two-Channel DAC Serial Command Front End

This block is the digital side of a two-channel 12-bit digital-to-analog converter. A host writes 16-bit command words over a receive-only SPI slave port (active-low chip select, serial clock, serial data). Each accepted word is split into a target channel, a reference-buffer setting, a gain setting, an output enable and a 12-bit code. The result is stored in that channel's staging register.

A separate active-low load strobe copies both staging registers into the active registers in the same cycle, so both channels change together. An active-low shutdown input disables both outputs. The serial port keeps working during shutdown.

All pins are synchronized into a fast system clock, and edges are detected there. The system clock must run at least four times the serial clock rate. The block drives out the active settings of each channel. It also gives a one-cycle pulse for each accepted word and for each start of a load.

Top module: `dacfe_top`

## Requirements
- R1: After reset, every channel reports code 0x000, output disabled, gain 2x (gain1x = 0) and reference unbuffered (buffered = 0).
- R2: Serial data is sampled on rising serial-clock edges while chip select is low, most significant bit first. This works whether the clock idles low or high.
- R3: Word fields: bit 15 selects the channel (0 = channel 0, 1 = channel 1); bit 14 = 1 selects buffered reference; bit 13 = 1 selects gain 1x and 0 selects 2x; bit 12 = 1 enables the output; bits 11..0 are the code.
- R4: A word is stored in the selected staging register when chip select rises after at least 16 clocks. `wr_commit` pulses high for exactly one cycle per stored word.
- R5: If chip select rises after fewer than 16 clocks, nothing is stored and `wr_commit` stays low.
- R6: Clock edges after the 16th in one frame are ignored. The stored word is the first 16 bits.
- R7: Staging registers have no effect on the outputs while the load strobe is high. While it is low, both active registers take the staging values.
- R8: `xfer_pulse` is high for exactly one cycle on each high-to-low transition of the load strobe.
- R9: While shutdown is low, both outputs are disabled, whatever is written or loaded. After shutdown returns high, an output turns on again only after a new write with bit 12 set, followed by a load.
- R10: Loading before any word has been accepted leaves the outputs at their reset values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset (power-on hold) |
| spi_csn | input | 1 | Serial chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_sdi | input | 1 | Serial data in |
| ldac_n | input | 1 | Load strobe, active low, level sensitive |
| shdn_n | input | 1 | Hardware shutdown, active low |
| chan_code | output | 24 | Active codes, channel 0 in bits 11..0 |
| chan_gain1x | output | 2 | Per channel: 1 = gain 1x, 0 = gain 2x |
| chan_buffered | output | 2 | Per channel: 1 = buffered reference |
| chan_enable | output | 2 | Per channel: 1 = output driven |
| wr_commit | output | 1 | One-cycle pulse per accepted word |
| xfer_pulse | output | 1 | One-cycle pulse per load strobe fall |

## Verification
Some properties are checked on every cycle:
- the active registers hold while the strobe is high, and copy the staging registers while it is low;
- shutdown clears both enables;
- the two pulses last one cycle;
- the shift register is frozen once 16 bits have arrived;
- a short frame never produces a commit.

Other behaviour only the bench scenarios can show: the bit order, the field decode into the correct channel in both clock idle levels, the values left after aborted or overlong frames, and the rule that enabling after shutdown needs a fresh write.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int WORD_W = 16;
    localparam int CODE_W = 12;
    localparam int NCH    = 2;
    localparam int SEL_W  = $clog2(NCH);
    localparam int CNT_W  = $clog2(WORD_W + 1);

    typedef struct packed {
        logic              buffered;
        logic              gain1x;
        logic              enable;
        logic [CODE_W-1:0] code;
    } chan_cfg_t;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        chan_cfg_t        cfg;
    } dac_cmd_t;

    localparam chan_cfg_t CFG_RESET = '0;

    function automatic dac_cmd_t decode_word(input logic [WORD_W-1:0] w);
        dac_cmd_t c;
        c.sel          = SEL_W'(w[WORD_W-1]);
        c.cfg.buffered = w[WORD_W-2];
        c.cfg.gain1x   = w[WORD_W-3];
        c.cfg.enable   = w[WORD_W-4];
        c.cfg.code     = w[CODE_W-1:0];
        return c;
    endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic lvl
);
    logic meta_q, lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= RST_VAL;
            lvl_q  <= RST_VAL;
        end else begin
            meta_q <= din;
            lvl_q  <= meta_q;
        end
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift
    import dacfe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              csn_lvl,
    input  logic              sck_lvl,
    input  logic              sdi_lvl,
    output logic              commit,
    output logic [WORD_W-1:0] word
);
    logic              csn_d, sck_d;
    logic              cs_fall, cs_rise, sck_rise;
    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;
    logic              commit_q;

    assign cs_fall  = csn_d & ~csn_lvl;
    assign cs_rise  = ~csn_d & csn_lvl;
    assign sck_rise = ~sck_d & sck_lvl;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d    <= 1'b1;
            sck_d    <= 1'b0;
            cnt_q    <= '0;
            sh_q     <= '0;
            commit_q <= 1'b0;
        end else begin
            csn_d    <= csn_lvl;
            sck_d    <= sck_lvl;
            commit_q <= 1'b0;
            if (cs_fall) begin
                cnt_q <= '0;
            end else if (!csn_lvl && sck_rise && cnt_q < CNT_W'(WORD_W)) begin
                sh_q  <= {sh_q[WORD_W-2:0], sdi_lvl};
                cnt_q <= cnt_q + 1'b1;
            end
            if (cs_rise && cnt_q == CNT_W'(WORD_W))
                commit_q <= 1'b1;
        end
    end

    assign commit = commit_q;
    assign word   = sh_q;

    // R6
    full_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == CNT_W'(WORD_W) && sck_rise && !cs_fall) |=> $stable(sh_q));

    // R5
    short_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && cnt_q != CNT_W'(WORD_W)) |=> !commit_q);

    // R4
    commit_single_chk: assert property (@(posedge clk) disable iff (rst)
        commit_q |=> !commit_q);
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
    import dacfe_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      commit,
    input  dac_cmd_t  cmd,
    input  logic      ldac_lvl,
    input  logic      shdn_lvl,
    output chan_cfg_t act
);
    chan_cfg_t stage_q, act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= CFG_RESET;
            act_q   <= CFG_RESET;
        end else begin
            if (commit && cmd.sel == SEL_W'(IDX))
                stage_q <= cmd.cfg;
            if (!ldac_lvl)
                act_q <= stage_q;
            if (!shdn_lvl) begin
                stage_q.enable <= 1'b0;
                act_q.enable   <= 1'b0;
            end
        end
    end

    assign act = act_q;

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ldac_lvl && shdn_lvl) |=> $stable(act_q));

    // R7
    copy_chk: assert property (@(posedge clk) disable iff (rst)
        (!ldac_lvl && shdn_lvl) |=> (act_q == $past(stage_q)));

    // R9
    shdn_off_chk: assert property (@(posedge clk) disable iff (rst)
        !shdn_lvl |=> (!act_q.enable && !stage_q.enable));
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  spi_csn,
    input  logic                  spi_sck,
    input  logic                  spi_sdi,
    input  logic                  ldac_n,
    input  logic                  shdn_n,
    output logic [NCH*CODE_W-1:0] chan_code,
    output logic [NCH-1:0]        chan_gain1x,
    output logic [NCH-1:0]        chan_buffered,
    output logic [NCH-1:0]        chan_enable,
    output logic                  wr_commit,
    output logic                  xfer_pulse
);
    localparam int         NSYNC    = 5;
    localparam logic [4:0] SYNC_RST = 5'b11001;

    logic [NSYNC-1:0]  raw, lvl;
    logic              commit;
    logic [WORD_W-1:0] word;
    dac_cmd_t          cmd;
    logic              ldac_d;

    assign raw = {shdn_n, ldac_n, spi_sdi, spi_sck, spi_csn};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        dacfe_sync #(.RST_VAL(SYNC_RST[g])) u_sync (
            .clk (clk),
            .rst (rst),
            .din (raw[g]),
            .lvl (lvl[g])
        );
    end

    dacfe_shift u_shift (
        .clk     (clk),
        .rst     (rst),
        .csn_lvl (lvl[0]),
        .sck_lvl (lvl[1]),
        .sdi_lvl (lvl[2]),
        .commit  (commit),
        .word    (word)
    );

    assign cmd = decode_word(word);

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        chan_cfg_t act;
        dacfe_chan #(.IDX(c)) u_chan (
            .clk      (clk),
            .rst      (rst),
            .commit   (commit),
            .cmd      (cmd),
            .ldac_lvl (lvl[3]),
            .shdn_lvl (lvl[4]),
            .act      (act)
        );
        assign chan_code[c*CODE_W +: CODE_W] = act.code;
        assign chan_gain1x[c]                = act.gain1x;
        assign chan_buffered[c]              = act.buffered;
        assign chan_enable[c]                = act.enable;
    end

    always_ff @(posedge clk) begin
        if (rst) ldac_d <= 1'b1;
        else     ldac_d <= lvl[3];
    end

    assign xfer_pulse = ldac_d & ~lvl[3];
    assign wr_commit  = commit;

    // R8
    xfer_single_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_pulse |=> !xfer_pulse);
endmodule

// File: tb/dacfe_top_tb_top.sv
module dacfe_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_csn = 1'b1, spi_sck = 1'b0, spi_sdi = 1'b0;
    logic        ldac_n = 1'b1, shdn_n = 1'b1;
    logic [23:0] chan_code;
    logic [1:0]  chan_gain1x, chan_buffered, chan_enable;
    logic        wr_commit, xfer_pulse;

    int n_checks = 0, n_fail = 0;
    int commit_cnt = 0, xfer_cnt = 0;

    // bench model: {buffered, gain1x, enable, code[11:0]}
    logic [14:0] exp_stage [2];
    logic [14:0] exp_act   [2];
    logic        exp_shdn_n = 1'b1;

    always #2 clk = ~clk;

    dacfe_top dut_i (
        .clk(clk), .rst(rst), .spi_csn(spi_csn), .spi_sck(spi_sck),
        .spi_sdi(spi_sdi), .ldac_n(ldac_n), .shdn_n(shdn_n),
        .chan_code(chan_code), .chan_gain1x(chan_gain1x),
        .chan_buffered(chan_buffered), .chan_enable(chan_enable),
        .wr_commit(wr_commit), .xfer_pulse(xfer_pulse)
    );

    always @(negedge clk) begin
        if (wr_commit)  commit_cnt++;
        if (xfer_pulse) xfer_cnt++;
    end

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [14:0] actual(input int c);
        return {chan_buffered[c], chan_gain1x[c], chan_enable[c], chan_code[c*12 +: 12]};
    endfunction

    task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        check_val(req, {2'b0, actual(1), actual(0)}, {2'b0, exp_act[1], exp_act[0]});
    endtask

    task automatic spi_frame(input logic [15:0] w, input int nclk, input bit idle_hi);
        spi_sck = idle_hi;
        spi_csn = 1'b0;
        wclk(5);
        for (int i = 0; i < nclk; i++) begin
            spi_sck = 1'b0;
            spi_sdi = (i < 16) ? w[15-i] : 1'($urandom);
            wclk(5);
            spi_sck = 1'b1;
            wclk(5);
        end
        if (!idle_hi) begin
            spi_sck = 1'b0;
            wclk(5);
        end
        spi_csn = 1'b1;
        wclk(12);
        if (nclk >= 16) begin
            exp_stage[w[15]] = {w[14], w[13], w[12] & exp_shdn_n, w[11:0]};
        end
    endtask

    task automatic load_pulse();
        ldac_n = 1'b0;
        wclk(6);
        ldac_n = 1'b1;
        wclk(8);
        exp_act[0] = exp_stage[0];
        exp_act[1] = exp_stage[1];
    endtask

    task automatic set_shdn(input logic v);
        shdn_n = v;
        exp_shdn_n = v;
        wclk(8);
        if (!v) begin
            for (int c = 0; c < 2; c++) begin
                exp_stage[c][12] = 1'b0;
                exp_act[c][12]   = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int c0, x0;
        void'($urandom(32'd20240611));
        exp_stage[0] = '0; exp_stage[1] = '0;
        exp_act[0]   = '0; exp_act[1]   = '0;
        wclk(6);
        rst = 1'b0;
        wclk(6);

        // R1: reset state
        check_outs("R1 reset");

        // R10 / R8: load before any write
        x0 = xfer_cnt;
        load_pulse();
        check_outs("R10 load without write");
        check_val("R8 xfer pulse count", xfer_cnt - x0, 1);

        // R4 / R7: write channel 0, clock idle low, no load yet
        c0 = commit_cnt;
        spi_frame(16'h7ABC, 16, 1'b0);
        check_val("R4 commit count", commit_cnt - c0, 1);
        check_outs("R7 stage does not reach outputs");
        load_pulse();
        check_outs("R3 channel 0 decode");

        // R2: write channel 1, clock idle high
        spi_frame(16'hD123, 16, 1'b1);
        load_pulse();
        check_outs("R2 idle-high capture channel 1");

        // R7: both channels staged, one load moves both
        spi_frame(16'h1555, 16, 1'b0);
        spi_frame(16'hB0F0, 16, 1'b1);
        check_outs("R7 hold before load");
        load_pulse();
        check_outs("R7 simultaneous load");

        // R5: aborted frame
        c0 = commit_cnt;
        spi_frame(16'h8FFF, 10, 1'b0);
        check_val("R5 no commit on short frame", commit_cnt - c0, 0);
        load_pulse();
        check_outs("R5 short frame ignored");

        // R6: overlong frame
        c0 = commit_cnt;
        spi_frame(16'h6A5A, 21, 1'b1);
        check_val("R6 overlong commits once", commit_cnt - c0, 1);
        load_pulse();
        check_outs("R6 first 16 bits kept");

        // R9: shutdown
        spi_frame(16'h9321, 16, 1'b0);
        load_pulse();
        set_shdn(1'b0);
        check_outs("R9 shutdown clears enables");
        spi_frame(16'h1777, 16, 1'b1);
        load_pulse();
        check_outs("R9 write during shutdown stays off");
        set_shdn(1'b1);
        load_pulse();
        check_outs("R9 release alone keeps off");
        spi_frame(16'h1888, 16, 1'b0);
        load_pulse();
        check_outs("R9 re-enable after write");

        // random mix, R3
        for (int k = 0; k < 40; k++) begin
            logic [15:0] w;
            int nc, sel;
            w   = 16'($urandom);
            sel = $urandom % 4;
            nc  = (sel == 1) ? 17 + ($urandom % 5) : (sel == 2) ? ($urandom % 16) : 16;
            c0  = commit_cnt;
            spi_frame(w, nc, 1'($urandom));
            check_val("R4 random commit count", commit_cnt - c0, (nc >= 16) ? 1 : 0);
            if ($urandom % 2) load_pulse();
            check_outs("R3 random word");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule